// File: doc/BRIEF.md
# Serial-to-Byte Deserializer with Stretch-Only Byte Clock

This block sits behind clock and data recovery. It runs on the bit-rate clock and takes one recovered serial bit on each cycle where the bit-valid enable is high. Each bit moves into a 10-bit shifter, whose contents go out every bit to an external comma detector. A bit counter marks symbol boundaries. At each boundary the completed symbol moves into a decode register, which keeps it until the next boundary. The same counter produces a byte-rate clock for the logic downstream.

When the comma detector finds a symbol boundary, it raises a realign request together with the last bit of that symbol. The block then ends the symbol on that bit and restarts its count. The byte clock never shows a short phase because of the realignment. If the request arrives while the clock is high, the high phase simply grows. If it arrives early in the low phase, the clock stays low until the following boundary. Either way, one period grows by no more than 9 bit times.

Top module: `byte_deser`

## Requirements
- R1: During and right after reset, `byte_clk` is 1, and `shift_q` and `dec_q` are all zero.
- R2: On each enabled bit, `shift_q` shifts one place toward bit 0 and takes `bit_in` into bit 9.
- R3: Every 10th enabled bit since the last boundary is a boundary. On that bit `dec_q` is loaded with the shifter contents including that bit, so the first bit of a symbol lands in bit 0. At all other times `dec_q` holds its value.
- R4: With no realign request, `byte_clk` rises on each boundary, stays high for 5 bit times and low for 5, giving a period of 10.
- R5: An enabled bit with `realign` high is itself a boundary: `dec_q` takes the shifter contents, the count restarts, and the next boundary comes 10 bits later.
- R6: A realign that lands while `byte_clk` is high, or on the last low bit, keeps `byte_clk` high for the next 5 bit times.
- R7: A realign that lands on one of the first four low bits keeps `byte_clk` low until the next boundary, exactly 10 bit times later.
- R8: Every high phase and every low phase of `byte_clk` lasts at least 5 bit times.
- R9: A byte-clock period that contains at most one realign lasts at most 19 bit times.
- R10: While `bit_en` is low, nothing changes, including when `realign` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | A recovered bit is present this cycle |
| bit_in | input | 1 | Recovered serial bit |
| realign | input | 1 | Comma found: this bit ends a symbol |
| shift_q | output | 10 | Shifter contents for the comma detector |
| dec_q | output | 10 | Last completed symbol |
| byte_clk | output | 1 | Byte-rate clock, stretch-only on realign |

## Verification
The hardest case to reach is a realign in the low phase. It must land on a chosen bit of the count, and it must be the only realign in its period, before the worst-case 19-bit period shows up. A directed sweep steps a bench model of the count to every one of the ten counter values in turn, fires one realign there, and measures how many bit times pass until the next clock edge. Random traffic with random enable gaps follows. In that traffic, realigns are spaced at least 25 bits apart, and every phase and period is timed against the bounds.

// File: rtl/byte_deser.sv
module byte_deser #(
  parameter int SYM_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic             realign,
  output logic [SYM_W-1:0] shift_q,
  output logic [SYM_W-1:0] dec_q,
  output logic             byte_clk
);
  localparam int CW = $clog2(SYM_W);
  localparam int HALF = SYM_W / 2;
  localparam int PW = $clog2(4 * SYM_W) + 1;
  localparam logic [CW-1:0] LAST = CW'(SYM_W - 1);
  localparam logic [CW-1:0] HALF_C = CW'(HALF);

  logic [CW-1:0] cnt, cnt_nxt;
  logic hold, hold_nxt;
  logic [SYM_W-1:0] sh_nxt;
  logic boundary, early_low, clk_nxt;

  assign sh_nxt    = {bit_in, shift_q[SYM_W-1:1]};
  assign boundary  = realign || (cnt == LAST);
  assign early_low = (cnt >= HALF_C) && (cnt != LAST);
  assign cnt_nxt   = boundary ? '0 : cnt + 1'b1;
  assign hold_nxt  = realign ? (hold | early_low) : (hold && cnt != LAST);
  assign byte_clk  = !hold && (cnt < HALF_C);
  assign clk_nxt   = !hold_nxt && (cnt_nxt < HALF_C);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      hold    <= 1'b0;
      shift_q <= '0;
      dec_q   <= '0;
    end else if (bit_en) begin
      shift_q <= sh_nxt;
      cnt     <= cnt_nxt;
      hold    <= hold_nxt;
      if (boundary) dec_q <= sh_nxt;
    end
  end

  logic [PW-1:0] pw, prd;
  logic [1:0] nrf;
  logic clk_edge, clk_rise;
  assign clk_edge = clk_nxt != byte_clk;
  assign clk_rise = clk_nxt && !byte_clk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pw  <= PW'(1);
      prd <= PW'(1);
      nrf <= '0;
    end else if (bit_en) begin
      pw <= clk_edge ? PW'(1) : ((&pw) ? pw : pw + 1'b1);
      if (clk_rise) begin
        prd <= PW'(1);
        nrf <= '0;
      end else begin
        prd <= (&prd) ? prd : prd + 1'b1;
        if (realign && nrf != 2'd3) nrf <= nrf + 1'b1;
      end
    end
  end

  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> shift_q[SYM_W-1] == $past(bit_in));
  p_dec_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && (realign || cnt == LAST)) |=>
      dec_q == {$past(bit_in), $past(shift_q[SYM_W-1:1])});
  p_dec_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !realign && cnt != LAST) |=> $stable(dec_q));
  p_rise_on_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_clk) |-> $past(bit_en && (realign || cnt == LAST)));
  p_min_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && clk_edge) |-> pw >= PW'(HALF));
  p_max_period_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && clk_rise && nrf <= 2'd1) |-> prd <= PW'(2 * SYM_W - 1));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(shift_q) && $stable(dec_q) && $stable(byte_clk));
endmodule

// File: tb/byte_deser_bench.sv
module byte_deser_bench;
  localparam int W = 10;
  localparam int H = W / 2;

  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, bit_in = 1'b0, realign = 1'b0;
  logic [W-1:0] shift_q, dec_q;
  logic byte_clk;

  byte_deser #(.SYM_W(W)) u_byte_deser (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in), .realign(realign),
    .shift_q(shift_q), .dec_q(dec_q), .byte_clk(byte_clk));

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int mc = 0;
  bit mh = 1'b0;
  logic [W-1:0] msh = '0, md = '0;
  int ph_len = 1, per_len = 1, rf_in = 0, since_rf = 100;
  bit seen_rise = 1'b0;
  logic prev_clk = 1'b1;

  function automatic bit exp_clk(int c, bit h);
    return !h && (c < H);
  endfunction

  task automatic check(string tag, string what, bit ok, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit en, bit b, bit rf);
    logic [W-1:0] nsh;
    bit bnd, rose;
    bit_en = en; bit_in = b; realign = rf;
    @(posedge clk); #1;
    if (en) begin
      nsh = {b, msh[W-1:1]};
      bnd = rf || (mc == W - 1);
      if (rf) mh = mh | (mc >= H && mc < W - 1);
      else if (mc == W - 1) mh = 1'b0;
      if (bnd) md = nsh;
      mc = bnd ? 0 : mc + 1;
      msh = nsh;
      since_rf = rf ? 0 : since_rf + 1;
    end
    check("R2", "shifter", shift_q === msh, int'(shift_q), int'(msh));
    check("R3", "decode register", dec_q === md, int'(dec_q), int'(md));
    check("R4", "byte clock level", byte_clk === exp_clk(mc, mh), int'(byte_clk), int'(exp_clk(mc, mh)));
    if (en) begin
      rose = byte_clk && !prev_clk;
      if (byte_clk != prev_clk) begin
        check("R8", "phase width", ph_len >= H, ph_len, H);
        if (rose && seen_rise && rf_in <= 1)
          check("R9", "period bound", per_len <= 2 * W - 1, per_len, 2 * W - 1);
        if (rose && seen_rise && rf_in == 0)
          check("R4", "nominal period", per_len == W, per_len, W);
        ph_len = 1;
      end else ph_len++;
      if (rose) begin
        seen_rise = 1'b1; per_len = 1; rf_in = 0;
      end else begin
        per_len++;
        if (rf) rf_in++;
      end
      prev_clk = byte_clk;
    end
    @(negedge clk);
  endtask

  task automatic phase_test(int c);
    int n;
    while (mc != c) step(1'b1, 1'($urandom), 1'b0);
    step(1'b1, 1'($urandom), 1'b1);
    check("R5", "load on realign", dec_q === shift_q, int'(dec_q), int'(shift_q));
    n = 0;
    if (c >= H && c < W - 1) begin
      check("R7", "low kept after realign", byte_clk == 1'b0, int'(byte_clk), 0);
      while (!byte_clk && n < 30) begin step(1'b1, 1'($urandom), 1'b0); n++; end
      check("R7", "bits until rise", n == W, n, W);
    end else begin
      check("R6", "high kept after realign", byte_clk == 1'b1, int'(byte_clk), 1);
      while (byte_clk && n < 30) begin step(1'b1, 1'($urandom), 1'b0); n++; end
      check("R6", "bits until fall", n == H, n, H);
    end
    repeat (25) step(1'b1, 1'($urandom), 1'b0);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL timeout (all requirements) actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pat, d0, s0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", "reset byte_clk", byte_clk === 1'b1, int'(byte_clk), 1);
    check("R1", "reset dec_q", dec_q === '0, int'(dec_q), 0);
    check("R1", "reset shift_q", shift_q === '0, int'(shift_q), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "byte_clk after reset", byte_clk === 1'b1, int'(byte_clk), 1);

    pat = 10'h2A5;
    for (int i = 0; i < W; i++) step(1'b1, pat[i], 1'b0);
    check("R3", "first bit at position 0", dec_q === pat, int'(dec_q), int'(pat));

    d0 = dec_q; s0 = shift_q;
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b1);
    check("R10", "dec_q idle", dec_q === d0, int'(dec_q), int'(d0));
    check("R10", "shift_q idle", shift_q === s0, int'(shift_q), int'(s0));

    for (int c = 0; c < W; c++) phase_test(c);

    for (int i = 0; i < 4000; i++) begin
      bit en, rf;
      en = ($urandom % 4) != 0;
      rf = en && since_rf >= 25 && ($urandom % 30) == 0;
      step(en, 1'($urandom), rf);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule